// File: doc/BRIEF.md
# Wide parallel PRBS-31 generator

This block produces a pseudo-random binary stream of maximal length from the feedback recurrence x^31 + x^28 + 1. It emits a whole word of consecutive stream bits on every enabled clock, 512 bits by default. At about 195 MHz that is roughly 100 Gb/s from a single moderate-speed clock. A 31-bit state register holds the next 31 bits that will leave the generator. Two XOR networks act on that register. One forms the next output word. The other forms the state as it would stand after a full word of single-bit shifts.

Both networks come from powers of the single-step transition matrix. Their equations are computed while the design elaborates, so each output bit and each next-state bit becomes a fixed XOR of a subset of the state bits.

The state is exactly a window of the stream. Software or a checker can therefore reload any 31 consecutive bits it has seen, and the generator then repeats the sequence from that point. Framing, error counting and the serial transmit path belong to neighbouring blocks.

Top module: `prbs_wide_gen`

## Requirements
- R1: Synchronous reset drives `word_o` to zero and `vld_o` low, and loads the reset seed (all ones by default). The first word after reset therefore starts with 31 ones.
- R2: Let s[0], s[1], ... be the stream, with s[i+31] = s[i+3] xor s[i]. Then on an advance, bit k of the new word equals stream bit n+k, where n is the index of the first bit the state held. Bit 0 is the earliest bit in stream order.
- R3: Successive advances deliver the stream with no gap and no overlap: the state moves forward by exactly WIDTH bits per advance.
- R4: The word is registered. `vld_o` is high in the cycle after an edge that had `adv_en` high and `seed_ld` low, and low after any other edge.
- R5: With `adv_en` low and `seed_ld` low, the word and the state hold. The next advance continues the stream where it stopped.
- R6: A seed load sets the state so that seed bit j is stream bit j from that point on. The next advance therefore begins with the seed bits in order, and then continues the recurrence.
- R7: When `seed_ld` and `adv_en` are high in the same cycle, the load wins. The word holds, `vld_o` goes low and no advance takes place.
- R8: An all-zero seed is replaced by the value 1 (only bit 0 set), so the state is never all zeros.
- R9: Reloading the first 31 bits of any word as a seed makes the next advance reproduce that word exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance by one word this cycle |
| seed_ld | input | 1 | Load `seed_i` into the state (takes priority) |
| seed_i | input | LFSR_LEN | Seed, bit 0 is the earliest stream bit |
| word_o | output | WIDTH | Registered output word, bit 0 earliest |
| vld_o | output | 1 | Word was produced by the previous edge |

## Verification
The state register is a literal copy of the next 31 stream bits. A corrupted state therefore shows in the first 31 bits of the very next word after an advance. A wrong jump equation leaves the current word correct, but breaks the stream at the head of the following word, so it shows within two advances. A wrong output equation shows in the same word, at bit positions 31 and above, or at any position in a word narrower than the state. Seeding from an observed word and expecting that word back ties the two networks together without any reference model.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    // Largest feedback register length supported by the mask function.
    localparam int MAX_LEN = 64;

    typedef logic [MAX_LEN-1:0] tapmask_t;

    // Returns the set of state bits whose XOR yields stream bit k.
    // The state holds stream bits 0..len-1. The recurrence is
    // s[i] = s[i-tap] ^ s[i-len]. A circular window of the last len masks
    // keeps the cost linear in k.
    function automatic tapmask_t stream_mask(int len, int tap, int k);
        tapmask_t win [MAX_LEN];
        for (int j = 0; j < MAX_LEN; j++) begin
            win[j] = (j < len) ? (tapmask_t'(1) << j) : '0;
        end
        for (int i = len; i <= k; i++) begin
            win[i % len] = win[(i - tap) % len] ^ win[i % len];
        end
        return win[k % len];
    endfunction

endpackage

// File: rtl/prbs_xor_net.sv
module prbs_xor_net
    import prbs_pkg::*;
#(
    parameter int LEN   = 31,
    parameter int TAP   = 28,
    parameter int BASE  = 0,
    parameter int COUNT = 8
) (
    input  logic [LEN-1:0]   state_i,
    output logic [COUNT-1:0] bits_o
);

    for (genvar k = 0; k < COUNT; k++) begin : g_bit
        if (BASE + k < LEN) begin : g_copy
            // Stream bit already sits in the state window.
            assign bits_o[k] = state_i[BASE + k];
        end else begin : g_xor
            localparam tapmask_t FULL = stream_mask(LEN, TAP, BASE + k);
            localparam logic [LEN-1:0] MASK = FULL[LEN-1:0];
            assign bits_o[k] = ^(state_i & MASK);
        end
    end

endmodule

// File: rtl/prbs_seed_guard.sv
module prbs_seed_guard #(
    parameter int LEN = 31,
    parameter logic [LEN-1:0] FALLBACK = LEN'(1)
) (
    input  logic [LEN-1:0] raw_i,
    output logic [LEN-1:0] safe_o
);

    // The all-zero state locks the generator, so it is never loaded.
    always_comb begin
        safe_o = raw_i;
        if (raw_i == '0) begin
            safe_o = FALLBACK;
        end
    end

endmodule

// File: rtl/prbs_wide_gen.sv
module prbs_wide_gen
    import prbs_pkg::*;
#(
    parameter int LFSR_LEN = 31,
    parameter int TAP      = 28,
    parameter int WIDTH    = 512,
    parameter logic [LFSR_LEN-1:0] RST_SEED = '1,
    parameter logic [LFSR_LEN-1:0] FALLBACK = LFSR_LEN'(1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv_en,
    input  logic                seed_ld,
    input  logic [LFSR_LEN-1:0] seed_i,
    output logic [WIDTH-1:0]    word_o,
    output logic                vld_o
);

    localparam logic [LFSR_LEN-1:0] RST_STATE = (RST_SEED == '0) ? FALLBACK : RST_SEED;

    typedef struct packed {
        logic [LFSR_LEN-1:0] state;
        logic [WIDTH-1:0]    word;
        logic                vld;
    } gen_regs_t;

    gen_regs_t gen_d, gen_q;

    logic [WIDTH-1:0]    word_next;
    logic [LFSR_LEN-1:0] state_jump;
    logic [LFSR_LEN-1:0] seed_safe;

    // Stream bits 0..WIDTH-1 relative to the current state.
    prbs_xor_net #(
        .LEN  (LFSR_LEN),
        .TAP  (TAP),
        .BASE (0),
        .COUNT(WIDTH)
    ) u_word_net (
        .state_i(gen_q.state),
        .bits_o (word_next)
    );

    // Stream bits WIDTH..WIDTH+LEN-1: the state after a whole word of shifts.
    prbs_xor_net #(
        .LEN  (LFSR_LEN),
        .TAP  (TAP),
        .BASE (WIDTH),
        .COUNT(LFSR_LEN)
    ) u_jump_net (
        .state_i(gen_q.state),
        .bits_o (state_jump)
    );

    prbs_seed_guard #(
        .LEN     (LFSR_LEN),
        .FALLBACK(FALLBACK)
    ) u_seed_guard (
        .raw_i (seed_i),
        .safe_o(seed_safe)
    );

    always_comb begin
        gen_d     = gen_q;
        gen_d.vld = 1'b0;
        if (seed_ld) begin
            gen_d.state = seed_safe;
        end else if (adv_en) begin
            gen_d.state = state_jump;
            gen_d.word  = word_next;
            gen_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q.state <= RST_STATE;
            gen_q.word  <= '0;
            gen_q.vld   <= 1'b0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign word_o = gen_q.word;
    assign vld_o  = gen_q.vld;

endmodule

// File: rtl/prbs_wide_gen_chk.sv
module prbs_wide_gen_chk #(
    parameter int LEN = 31,
    parameter int W   = 512,
    parameter logic [LEN-1:0] FALLBACK = LEN'(1)
) (
    input logic           clk,
    input logic           rst,
    input logic           adv_en,
    input logic           seed_ld,
    input logic [LEN-1:0] seed_i,
    input logic [W-1:0]   word_o,
    input logic           vld_o,
    input logic [LEN-1:0] state_q
);

    localparam int HEAD = (W < LEN) ? W : LEN;

    AST_VLD_ON_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !seed_ld) |=> vld_o); // R4

    AST_VLD_OFF_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        !(adv_en && !seed_ld) |=> !vld_o); // R4

    AST_WORD_HEAD_FROM_STATE: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !seed_ld) |=> (word_o[HEAD-1:0] == $past(state_q[HEAD-1:0]))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!adv_en && !seed_ld) |=> ($stable(word_o) && $stable(state_q))); // R5

    AST_SEED_WINS: assert property (@(posedge clk) disable iff (rst)
        seed_ld |=> ($stable(word_o) && !vld_o)); // R7

    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (seed_ld && seed_i != '0) |=> (state_q == $past(seed_i))); // R6

    AST_ZERO_SEED_REPLACED: assert property (@(posedge clk) disable iff (rst)
        (seed_ld && seed_i == '0) |=> (state_q == FALLBACK)); // R8

    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R8

endmodule

bind prbs_wide_gen prbs_wide_gen_chk #(
    .LEN     (LFSR_LEN),
    .W       (WIDTH),
    .FALLBACK(FALLBACK)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .adv_en (adv_en),
    .seed_ld(seed_ld),
    .seed_i (seed_i),
    .word_o (word_o),
    .vld_o  (vld_o),
    .state_q(gen_q.state)
);

// File: tb/test_prbs_wide_gen.sv
`timescale 1ns/1ps
module test_prbs_wide_gen;

    localparam int N  = 31;
    localparam int WA = 8;
    localparam int WB = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          adv_en = 1'b0;
    logic          seed_ld = 1'b0;
    logic [N-1:0]  seed_i = '0;
    logic [WA-1:0] word_a;
    logic          vld_a;
    logic [WB-1:0] word_b;
    logic          vld_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [N-1:0]  ref_a, ref_b;
    logic [WA-1:0] exp_a;
    logic [WB-1:0] exp_b;
    logic [WB-1:0] cap;

    always #2 clk = ~clk;

    prbs_wide_gen #(.LFSR_LEN(N), .TAP(28), .WIDTH(WA)) i_prbs_wide_gen (
        .clk(clk), .rst(rst), .adv_en(adv_en), .seed_ld(seed_ld),
        .seed_i(seed_i), .word_o(word_a), .vld_o(vld_a)
    );

    prbs_wide_gen #(.LFSR_LEN(N), .TAP(28), .WIDTH(WB)) i_prbs_wide_gen_wide (
        .clk(clk), .rst(rst), .adv_en(adv_en), .seed_ld(seed_ld),
        .seed_i(seed_i), .word_o(word_b), .vld_o(vld_b)
    );

    // One serial step: window holds stream bits n..n+30, bit 0 earliest.
    function automatic logic [N-1:0] shift1(logic [N-1:0] r);
        return {r[3] ^ r[0], r[N-1:1]};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic tick(string tag, logic a, logic l, logic [N-1:0] s);
        logic [N-1:0] sv;
        adv_en  = a;
        seed_ld = l;
        seed_i  = s;
        @(posedge clk);
        #1;
        if (l) begin
            sv    = (s == '0) ? N'(1) : s;
            ref_a = sv;
            ref_b = sv;
        end else if (a) begin
            for (int k = 0; k < WA; k++) begin
                exp_a[k] = ref_a[0];
                ref_a    = shift1(ref_a);
            end
            for (int k = 0; k < WB; k++) begin
                exp_b[k] = ref_b[0];
                ref_b    = shift1(ref_b);
            end
        end
        chk(tag, "word_a", 64'(word_a), 64'(exp_a));
        chk(tag, "word_b", 64'(word_b), 64'(exp_b));
        chk(tag, "vld_a", 64'(vld_a), 64'(a && !l));
        chk(tag, "vld_b", 64'(vld_b), 64'(a && !l));
    endtask

    task automatic do_reset();
        adv_en  = 1'b0;
        seed_ld = 1'b0;
        rst     = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared while in reset
        chk("R1", "word_a rst", 64'(word_a), 64'd0);
        chk("R1", "word_b rst", 64'(word_b), 64'd0);
        chk("R1", "vld_a rst", 64'(vld_a), 64'd0);
        chk("R1", "vld_b rst", 64'(vld_b), 64'd0);
        rst   = 1'b0;
        ref_a = '1;
        ref_b = '1;
        exp_a = '0;
        exp_b = '0;
        tick("R1", 1'b1, 1'b0, '0);
        chk("R1", "first word_a ones", 64'(word_a), 64'hFF);
        chk("R1", "first word_b head ones", 64'(word_b[30:0]), 64'h7FFF_FFFF);
    endtask

    initial begin
        logic [31:0] r;
        do_reset();

        // R2: plain stream generation
        for (int i = 0; i < 30; i++) tick("R2", 1'b1, 1'b0, '0);

        // R3: long run of back-to-back words
        for (int i = 0; i < 100; i++) tick("R3", 1'b1, 1'b0, '0);

        // R5: idle cycles hold, then resume
        for (int i = 0; i < 4; i++) tick("R5", 1'b0, 1'b0, '0);
        for (int i = 0; i < 6; i++) tick("R5", 1'b1, 1'b0, '0);

        // R6: seed load then advance starts with the seed
        tick("R6", 1'b0, 1'b1, 31'h2345_6789);
        tick("R6", 1'b1, 1'b0, '0);
        chk("R6", "word_b head is seed", 64'(word_b[30:0]), 64'h2345_6789);
        chk("R6", "word_a is seed low", 64'(word_a), 64'h89);
        for (int i = 0; i < 5; i++) tick("R6", 1'b1, 1'b0, '0);

        // R7: load and advance together, load wins
        cap = word_b;
        tick("R7", 1'b1, 1'b1, 31'h0F0F_1357);
        chk("R7", "word_b held", 64'(word_b), 64'(cap));
        tick("R7", 1'b1, 1'b0, '0);
        chk("R7", "word_a from seed", 64'(word_a), 64'h57);

        // R8: zero seed replaced by 1
        tick("R8", 1'b0, 1'b1, '0);
        tick("R8", 1'b1, 1'b0, '0);
        chk("R8", "word_a after zero seed", 64'(word_a), 64'h01);
        chk("R8", "word_b after zero seed", 64'(word_b), 64'h00_8000_0001);

        // R9: reseed from an observed word reproduces it
        for (int i = 0; i < 7; i++) tick("R9", 1'b1, 1'b0, '0);
        cap = word_b;
        tick("R9", 1'b1, 1'b0, '0);
        tick("R9", 1'b0, 1'b1, cap[30:0]);
        tick("R9", 1'b1, 1'b0, '0);
        chk("R9", "word_b replay", 64'(word_b), 64'(cap));

        // Mixed sweep of advance, idle, load and zero load
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            tick("R3", r[0] | r[1], (r[7:4] == 4'd0),
                 (r[11:8] == 4'd0) ? N'(0) : N'($urandom));
        end

        // R1: reset in the middle of a run
        do_reset();
        for (int i = 0; i < 10; i++) tick("R2", 1'b1, 1'b0, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule